// File: doc/BRIEF.md
# Transmit FIFO Pacer with Fill and Drain Thresholds

The block sits between a transmit DMA engine and a MAC transmitter. It holds outgoing frames in a word-wide FIFO where every word carries an end-of-frame flag. It decides two things. The first is when the DMA engine may ask for the bus, and for how many words. The second is when the MAC may begin sending.

DMA refill waits until the FIFO has free space at least equal to a programmable fill level. The burst granted is the smaller of a coded maximum and the free space. A single-word mode applies only on a gigabit half-duplex link. The MAC start signal is raised in either of two cases: the stored data reaches a programmable drain level, or at least one whole frame sits in the FIFO. A drain level of zero turns the FIFO into a store-and-forward buffer. Both levels are counted in 32-byte units, which is 8 words of 32 bits. Settings that could deadlock set a sticky error flag, and that flag blocks DMA requests.

Configuration is captured on `cfg_load`. A hard reset (`rst_n`) and a soft clear (`soft_clr`) both return the configuration to zero, empty the FIFO, clear the error flag and put both state machines in their idle states.

DMA state machine: `D_IDLE` moves to `D_REQ` when there is no error, the fill level is nonzero and free words are at least 8 × fill level. At that moment the grant is latched. `D_REQ` returns to `D_IDLE` when the last granted word is written, or when the error flag is set.

MAC state machine: `M_WAIT` moves to `M_SEND` when a complete frame is stored, or when the drain level is nonzero and stored words are at least 8 × drain level. `M_SEND` returns to `M_WAIT` when the MAC reads a word flagged end-of-frame.

Top module: `txq_pacer`

## Requirements
- R1: The granted length `dma_burst_len` is the smaller of the free words and the coded maximum. The code maps 0→256, 1→2, 2→4, 3→8, 4→16, 5→32, 6→64, 7→128 words. It is 0 while no request is raised.
- R2: With `cfg_single_beat`=1, `link_gig`=1 and `link_full_dup`=0, the grant is 1 word. In every other link combination the bit has no effect.
- R3: `dma_req` rises only when the stored fill level is nonzero and the free words were at least 8 × fill level in the cycle before. It rises one cycle after that condition is met.
- R4: A `cfg_load` whose fill level is 0, or whose (fill + drain) × 8 exceeds DEPTH, sets `config_error` on that edge. The flag stays set until reset or soft clear, even if valid settings are loaded later. From the cycle after it is set, `dma_req` stays low.
- R5: `dma_req` drops on the edge where the last granted word is written. The request is re-evaluated on the following edge.
- R6: With a nonzero drain level, `tx_start` rises one cycle after the stored words reach 8 × drain level.
- R7: `tx_start` rises one cycle after a whole frame is stored. With drain level 0, partial frames never start transmission.
- R8: Once raised, `tx_start` stays high until the MAC reads an end-of-frame word, even if occupancy falls below the drain level. It drops on that read edge.
- R9: Words and their end-of-frame flags leave the FIFO in write order, first-word-fall-through, with `rd_valid` high while the FIFO is not empty.
- R10: Writing and reading end-of-frame words in the same cycle leaves the frame count unchanged.
- R11: After hard reset or soft clear: `dma_req`, `tx_start`, `config_error` and `rd_valid` are 0, and `dma_burst_len` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| soft_clr | input | 1 | Synchronous clear of configuration, FIFO and state |
| cfg_load | input | 1 | Capture the configuration fields |
| cfg_burst_code | input | 3 | Maximum burst code (R1) |
| cfg_single_beat | input | 1 | Single-word bursts on gigabit half-duplex |
| cfg_fill_units | input | TH_W (7) | Fill level, 32-byte units |
| cfg_drain_units | input | TH_W (7) | Drain level, 32-byte units |
| link_gig | input | 1 | Link runs at 1000 Mb/s |
| link_full_dup | input | 1 | Link is full-duplex |
| wr_en | input | 1 | DMA writes a word |
| wr_data | input | DATA_W (32) | Write word |
| wr_eop | input | 1 | Write word ends a frame |
| rd_en | input | 1 | MAC reads the head word |
| rd_data | output | DATA_W (32) | Head word |
| rd_eop | output | 1 | Head word ends a frame |
| rd_valid | output | 1 | FIFO not empty |
| dma_req | output | 1 | DMA bus request |
| dma_burst_len | output | GRANT_W (10) | Granted words for this request |
| tx_start | output | 1 | MAC may transmit |
| config_error | output | 1 | Sticky invalid-configuration flag |

## Verification
The assertions assume that the DMA engine writes only while the FIFO is not full and the MAC reads only while `rd_valid` is high. The checks on the request also assume that configuration changes reach the FSM only through `cfg_load`. The stimulus writes at most one frame plus a few words, far below the 512-word depth, and reads only words it has queued itself. The stimulus also changes the link inputs only between soft clears, so a grant is never judged against link values that moved mid-decision.

// File: rtl/txq_pkg.sv
package txq_pkg;
    localparam int BURST_W = 9;

    typedef enum logic {D_IDLE, D_REQ} dma_state_e;
    typedef enum logic {M_WAIT, M_SEND} mac_state_e;

    // Maximum burst in words for a 3-bit code: 0 means 256, n means 2**n.
    function automatic logic [BURST_W-1:0] burst_words(input logic [2:0] code);
        if (code == 3'd0) return BURST_W'(256);
        return BURST_W'(1) << code;
    endfunction
endpackage

// File: rtl/txq_fifo.sv
module txq_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_eop,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_eop,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  occ,
    output logic [CNT_W-1:0]  pkt_cnt
);
    logic [DATA_W:0]    mem [DEPTH];
    logic [PTR_W-1:0]   wptr, rptr;
    logic [CNT_W-1:0]   occ_q, pkt_q;
    logic               wr_ok, rd_ok, wr_eop_ok, rd_eop_ok;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    assign wr_ok     = wr_en && (occ_q != CNT_W'(DEPTH));
    assign rd_ok     = rd_en && (occ_q != '0);
    assign wr_eop_ok = wr_ok && wr_eop;
    assign rd_eop_ok = rd_ok && mem[rptr][DATA_W];

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= {wr_eop, wr_data};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            occ_q <= '0;
            pkt_q <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            occ_q <= '0;
            pkt_q <= '0;
        end else begin
            if (wr_ok) wptr <= ptr_next(wptr);
            if (rd_ok) rptr <= ptr_next(rptr);
            occ_q <= occ_q + CNT_W'(wr_ok) - CNT_W'(rd_ok);
            pkt_q <= pkt_q + CNT_W'(wr_eop_ok) - CNT_W'(rd_eop_ok);
        end
    end

    assign rd_data  = mem[rptr][DATA_W-1:0];
    assign rd_eop   = mem[rptr][DATA_W];
    assign rd_valid = (occ_q != '0);
    assign occ      = occ_q;
    assign pkt_cnt  = pkt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= CNT_W'(DEPTH)); // R9
    AST_FRAMES_FIT: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_q <= occ_q); // R10
    AST_EOP_SWAP: assert property (@(posedge clk) disable iff (!rst_n || clr)
        wr_eop_ok && rd_eop_ok |=> $stable(pkt_cnt)); // R10
endmodule

// File: rtl/txq_dma_ctrl.sv
module txq_dma_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int TH_W  = 7,
    parameter int WPU   = 8,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int GRANT_W = (CNT_W > BURST_W) ? CNT_W : BURST_W,
    localparam int CMP_W   = CNT_W + TH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               cfg_err,
    input  logic [TH_W-1:0]    fill_th,
    input  logic [2:0]         burst_code,
    input  logic               single_beat,
    input  logic               link_gig,
    input  logic               link_full_dup,
    input  logic [CNT_W-1:0]   free_words,
    input  logic               wr_en,
    output logic               dma_req,
    output logic [GRANT_W-1:0] dma_burst_len
);
    dma_state_e         state, state_n;
    logic [GRANT_W-1:0] grant_q, rem_q, grant_calc, max_ext, free_ext;
    logic [CMP_W-1:0]   fill_words;
    logic               fill_ok, one_word;

    assign fill_words = CMP_W'(fill_th) * CMP_W'(WPU);
    assign fill_ok    = (fill_th != '0) && (CMP_W'(free_words) >= fill_words);
    assign one_word   = single_beat && link_gig && !link_full_dup;
    assign max_ext    = one_word ? GRANT_W'(1) : GRANT_W'(burst_words(burst_code));
    assign free_ext   = GRANT_W'(free_words);
    assign grant_calc = (max_ext < free_ext) ? max_ext : free_ext;

    always_comb begin
        state_n = state;
        unique case (state)
            D_IDLE: if (!cfg_err && fill_ok) state_n = D_REQ;
            D_REQ: begin
                if (cfg_err)                                 state_n = D_IDLE;
                else if (wr_en && rem_q == GRANT_W'(1))      state_n = D_IDLE;
            end
            default: state_n = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= D_IDLE;
            grant_q <= '0;
            rem_q   <= '0;
        end else if (clr) begin
            state   <= D_IDLE;
            grant_q <= '0;
            rem_q   <= '0;
        end else begin
            state <= state_n;
            if (state == D_IDLE) begin
                grant_q <= grant_calc;
                rem_q   <= grant_calc;
            end else if (wr_en && rem_q != '0) begin
                rem_q <= rem_q - GRANT_W'(1);
            end
        end
    end

    always_comb begin
        dma_req       = 1'b0;
        dma_burst_len = '0;
        unique case (state)
            D_IDLE: ;
            D_REQ: begin
                dma_req       = 1'b1;
                dma_burst_len = grant_q;
            end
            default: ;
        endcase
    end

    AST_REQ_FILL: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(dma_req) |-> $past(CMP_W'(free_words) >= fill_words) && $past(fill_th != '0)); // R3
    AST_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n || clr)
        cfg_err && $past(cfg_err) |-> !dma_req); // R4
    AST_GRANT_FIT: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(dma_req) |-> dma_burst_len != '0 && dma_burst_len <= $past(free_ext)); // R1
    AST_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(dma_req) && $past(one_word) |-> dma_burst_len == GRANT_W'(1)); // R2
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n || clr)
        dma_req && wr_en && rem_q == GRANT_W'(1) |=> !dma_req); // R5
endmodule

// File: rtl/txq_mac_ctrl.sv
module txq_mac_ctrl
    import txq_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int TH_W  = 7,
    parameter int WPU   = 8,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int CMP_W = CNT_W + TH_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [TH_W-1:0]  drain_th,
    input  logic [CNT_W-1:0] occ,
    input  logic [CNT_W-1:0] pkt_cnt,
    input  logic             rd_eop_fire,
    output logic             tx_start
);
    mac_state_e       state, state_n;
    logic [CMP_W-1:0] drain_words;
    logic             go;

    assign drain_words = CMP_W'(drain_th) * CMP_W'(WPU);
    assign go = (pkt_cnt != '0) ||
                ((drain_th != '0) && (CMP_W'(occ) >= drain_words));

    always_comb begin
        state_n = state;
        unique case (state)
            M_WAIT:  if (go) state_n = M_SEND;
            M_SEND:  if (rd_eop_fire) state_n = M_WAIT;
            default: state_n = M_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   state <= M_WAIT;
        else if (clr) state <= M_WAIT;
        else          state <= state_n;
    end

    always_comb begin
        tx_start = 1'b0;
        unique case (state)
            M_WAIT:  tx_start = 1'b0;
            M_SEND:  tx_start = 1'b1;
            default: tx_start = 1'b0;
        endcase
    end

    AST_START_HOLD: assert property (@(posedge clk) disable iff (!rst_n || clr)
        tx_start && !rd_eop_fire |=> tx_start); // R8
    AST_START_CAUSE: assert property (@(posedge clk) disable iff (!rst_n || clr)
        $rose(tx_start) |-> $past(go)); // R7
    AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_n || clr)
        tx_start && rd_eop_fire |=> !tx_start); // R8
endmodule

// File: rtl/txq_pacer.sv
module txq_pacer
    import txq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 512,
    parameter int TH_W   = 7,
    localparam int WPU     = 256 / DATA_W,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int GRANT_W = (CNT_W > BURST_W) ? CNT_W : BURST_W,
    localparam int CMP_W   = CNT_W + TH_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_clr,
    input  logic               cfg_load,
    input  logic [2:0]         cfg_burst_code,
    input  logic               cfg_single_beat,
    input  logic [TH_W-1:0]    cfg_fill_units,
    input  logic [TH_W-1:0]    cfg_drain_units,
    input  logic               link_gig,
    input  logic               link_full_dup,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               wr_eop,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  rd_data,
    output logic               rd_eop,
    output logic               rd_valid,
    output logic               dma_req,
    output logic [GRANT_W-1:0] dma_burst_len,
    output logic               tx_start,
    output logic               config_error
);
    logic [2:0]       code_q;
    logic             beat_q, err_q, bad_cfg, rd_eop_fire;
    logic [TH_W-1:0]  fill_q, drain_q;
    logic [CNT_W-1:0] occ, pkt_cnt, free_words;

    assign bad_cfg = (cfg_fill_units == '0) ||
        ((CMP_W'(cfg_fill_units) + CMP_W'(cfg_drain_units)) * CMP_W'(WPU) > CMP_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0; beat_q <= 1'b0; fill_q <= '0; drain_q <= '0; err_q <= 1'b0;
        end else if (soft_clr) begin
            code_q <= '0; beat_q <= 1'b0; fill_q <= '0; drain_q <= '0; err_q <= 1'b0;
        end else if (cfg_load) begin
            code_q  <= cfg_burst_code;
            beat_q  <= cfg_single_beat;
            fill_q  <= cfg_fill_units;
            drain_q <= cfg_drain_units;
            if (bad_cfg) err_q <= 1'b1;
        end
    end

    assign config_error = err_q;
    assign free_words   = CNT_W'(DEPTH) - occ;
    assign rd_eop_fire  = rd_en && rd_valid && rd_eop;

    txq_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
        .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop), .rd_valid(rd_valid),
        .occ(occ), .pkt_cnt(pkt_cnt)
    );

    txq_dma_ctrl #(.DEPTH(DEPTH), .TH_W(TH_W), .WPU(WPU)) u_dma (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .cfg_err(err_q),
        .fill_th(fill_q), .burst_code(code_q), .single_beat(beat_q),
        .link_gig(link_gig), .link_full_dup(link_full_dup),
        .free_words(free_words), .wr_en(wr_en),
        .dma_req(dma_req), .dma_burst_len(dma_burst_len)
    );

    txq_mac_ctrl #(.DEPTH(DEPTH), .TH_W(TH_W), .WPU(WPU)) u_mac (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr), .drain_th(drain_q),
        .occ(occ), .pkt_cnt(pkt_cnt), .rd_eop_fire(rd_eop_fire),
        .tx_start(tx_start)
    );

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        config_error && !soft_clr |=> config_error); // R4
    AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> !dma_req && !tx_start && !config_error && !rd_valid); // R11
endmodule

// File: tb/txq_pacer_bench.sv
`timescale 1ns/1ps
module txq_pacer_bench;
    localparam int DW = 32;
    localparam int TW = 7;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0, soft_clr = 1'b0, cfg_load = 1'b0;
    logic [2:0]    cfg_burst_code = '0;
    logic          cfg_single_beat = 1'b0;
    logic [TW-1:0] cfg_fill_units = '0, cfg_drain_units = '0;
    logic          link_gig = 1'b0, link_full_dup = 1'b1;
    logic          wr_en = 1'b0, wr_eop = 1'b0, rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          rd_eop, rd_valid, dma_req, tx_start, config_error;
    logic [9:0]    dma_burst_len;

    int            n_chk = 0, n_fail = 0;
    bit            done = 1'b0;
    logic [DW:0]   exp_q[$];
    logic [DW:0]   item;

    always #2.5 clk = ~clk;

    txq_pacer u_txq_pacer (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr), .cfg_load(cfg_load),
        .cfg_burst_code(cfg_burst_code), .cfg_single_beat(cfg_single_beat),
        .cfg_fill_units(cfg_fill_units), .cfg_drain_units(cfg_drain_units),
        .link_gig(link_gig), .link_full_dup(link_full_dup),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop), .rd_en(rd_en),
        .rd_data(rd_data), .rd_eop(rd_eop), .rd_valid(rd_valid),
        .dma_req(dma_req), .dma_burst_len(dma_burst_len),
        .tx_start(tx_start), .config_error(config_error)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic cfg(input logic [2:0] code, input logic beat, input int fill, input int drain);
        cfg_burst_code = code; cfg_single_beat = beat;
        cfg_fill_units = TW'(fill); cfg_drain_units = TW'(drain);
        cfg_load = 1'b1; tick(); cfg_load = 1'b0;
    endtask

    task automatic sclr();
        soft_clr = 1'b1; tick(); soft_clr = 1'b0;
        exp_q.delete();
    endtask

    task automatic push(input logic [DW-1:0] d, input logic e);
        wr_en = 1'b1; wr_data = d; wr_eop = e; exp_q.push_back({e, d});
        tick(); wr_en = 1'b0; wr_eop = 1'b0;
    endtask

    task automatic pop();
        rd_en = 1'b1; tick(); rd_en = 1'b0;
    endtask

    task automatic push_pop(input logic [DW-1:0] d, input logic e);
        wr_en = 1'b1; wr_data = d; wr_eop = e; exp_q.push_back({e, d});
        rd_en = 1'b1; tick(); wr_en = 1'b0; wr_eop = 1'b0; rd_en = 1'b0;
    endtask

    // Monitor: compares each read word against the scoreboard queue (R9).
    always @(negedge clk) begin
        #1;
        if (rd_en && !done) begin
            if (exp_q.size() == 0) begin
                chk("R9 read from empty scoreboard", 1, 0);
            end else begin
                item = exp_q.pop_front();
                chk("R9 rd_valid", int'(rd_valid), 1);
                chk("R9 rd_data", int'(rd_data), int'(item[DW-1:0]));
                chk("R9 rd_eop", int'(rd_eop), int'(item[DW]));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R11: reset state
        chk("R11 dma_req", int'(dma_req), 0);
        chk("R11 tx_start", int'(tx_start), 0);
        chk("R11 config_error", int'(config_error), 0);
        chk("R11 rd_valid", int'(rd_valid), 0);
        chk("R11 dma_burst_len", int'(dma_burst_len), 0);
        tick();
        chk("R3 no request with zero fill", int'(dma_req), 0);

        // R1: burst code decode against 512 free words
        for (int c = 0; c < 8; c++) begin
            sclr();
            cfg(3'(c), 1'b0, 1, 0);
            tick();
            chk("R1 burst length", int'(dma_burst_len), (c == 0) ? 256 : (1 << c));
        end

        // R2: single-beat mode only on gigabit half-duplex
        sclr(); link_gig = 1'b1; link_full_dup = 1'b0;
        cfg(3'd0, 1'b1, 1, 0); tick();
        chk("R2 gig half single", int'(dma_burst_len), 1);
        sclr(); link_gig = 1'b1; link_full_dup = 1'b1;
        cfg(3'd0, 1'b1, 1, 0); tick();
        chk("R2 gig full no effect", int'(dma_burst_len), 256);
        sclr(); link_gig = 1'b0; link_full_dup = 1'b0;
        cfg(3'd0, 1'b1, 1, 0); tick();
        chk("R2 slow half no effect", int'(dma_burst_len), 256);
        link_full_dup = 1'b1;

        // R4: sticky configuration error
        sclr();
        cfg(3'd0, 1'b0, 0, 0);
        chk("R4 zero fill error", int'(config_error), 1);
        tick();
        chk("R4 no request on error", int'(dma_req), 0);
        cfg(3'd0, 1'b0, 1, 0); tick(); tick();
        chk("R4 error sticky", int'(config_error), 1);
        chk("R4 request held off", int'(dma_req), 0);
        sclr();
        chk("R11 soft clear error", int'(config_error), 0);
        cfg(3'd0, 1'b0, 60, 5);
        chk("R4 deadlock error", int'(config_error), 1);
        sclr();
        cfg(3'd0, 1'b0, 60, 4); tick();
        chk("R4 boundary valid", int'(config_error), 0);
        chk("R4 boundary request", int'(dma_req), 1);

        // R3: fill gating on free space
        sclr();
        push(32'hA5A5_0001, 1'b0);
        cfg(3'd0, 1'b0, 64, 0); tick(); tick();
        chk("R3 511 free below level", int'(dma_req), 0);
        pop();
        chk("R3 not yet evaluated", int'(dma_req), 0);
        tick();
        chk("R3 request at full space", int'(dma_req), 1);
        chk("R1 grant at full space", int'(dma_burst_len), 256);

        // R5 / R7: burst completion and store-and-forward
        sclr();
        cfg(3'd1, 1'b0, 1, 0); tick();
        chk("R5 first request", int'(dma_req), 1);
        chk("R5 first grant", int'(dma_burst_len), 2);
        push(32'h1111_0000, 1'b0);
        chk("R5 held mid burst", int'(dma_req), 1);
        push(32'h1111_0001, 1'b0);
        chk("R5 dropped after grant", int'(dma_req), 0);
        tick();
        chk("R5 re-raised", int'(dma_req), 1);
        chk("R5 regrant", int'(dma_burst_len), 2);
        chk("R7 partial frame no start", int'(tx_start), 0);
        push(32'h1111_0002, 1'b0);
        push(32'h1111_0003, 1'b1);
        chk("R7 start one cycle later", int'(tx_start), 0);
        tick();
        chk("R7 whole frame start", int'(tx_start), 1);
        for (int i = 0; i < 4; i++) pop();
        chk("R8 drop on eop read", int'(tx_start), 0);
        tick();
        chk("R7 stays idle when empty", int'(tx_start), 0);

        // R6 / R8: drain level and hold
        sclr();
        cfg(3'd0, 1'b0, 1, 1);
        for (int i = 0; i < 7; i++) push(32'h2222_0000 + DW'(i), 1'b0);
        tick();
        chk("R6 below drain level", int'(tx_start), 0);
        push(32'h2222_0007, 1'b0);
        tick();
        chk("R6 drain level reached", int'(tx_start), 1);
        pop(); pop();
        chk("R8 held below level", int'(tx_start), 1);
        push(32'h2222_0008, 1'b1);
        for (int i = 0; i < 6; i++) pop();
        chk("R8 held until eop", int'(tx_start), 1);
        pop();
        chk("R8 drop after eop", int'(tx_start), 0);

        // R10: simultaneous eop write and read
        sclr();
        cfg(3'd0, 1'b0, 1, 0);
        push(32'h3333_000A, 1'b1);
        tick();
        chk("R10 frame A start", int'(tx_start), 1);
        push_pop(32'h3333_000B, 1'b1);
        chk("R10 drop on A eop", int'(tx_start), 0);
        tick();
        chk("R10 frame B still counted", int'(tx_start), 1);
        pop();
        tick(); tick();
        chk("R10 no phantom frame", int'(tx_start), 0);

        // R11: soft clear empties the FIFO
        push(32'h4444_0000, 1'b0);
        chk("R11 word stored", int'(rd_valid), 1);
        sclr();
        chk("R11 soft clear empties", int'(rd_valid), 0);

        tick();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule